// File: doc/BRIEF.md
# Combinational Shift Execution Stage

This block carries out the shift-class integer operations of an execution pipeline. Its inputs are a 64-bit source operand, a 64-bit operand that holds the shift count, a 3-bit operation code, a word-mode flag and a signedness flag. A context tag travels alongside: an operation record and a mux id. The block has no clock and no state. In the same cycle it returns a 64-bit result, a valid flag and the context tag, unchanged.

It performs three operations. The first is a logical left shift. The second is a right shift, either logical or arithmetic. The third sign-extends the low word of the source and then shifts it left.

In doubleword mode (word-mode flag low) the shift count is the low 7 bits of the count operand, so counts from 64 to 127 are legal. In word mode the count is the low 6 bits and the result is computed on the low 32 bits.

The style of this code base calls for named states. Here that role is taken by a decoded operation class with four values:
- `K_NONE`: the opcode is not supported.
- `K_LEFT`: logical left shift.
- `K_RIGHT`: right shift.
- `K_EXTL`: sign-extend the low word, then shift left.

The opcode decoder maps each opcode to one class. That mapping is the only transition the block has, and it settles in the same cycle.

Top module: `shx_stage`

## Requirements
- R1: Opcode 0 (shift left) in doubleword mode returns the source shifted left by the count, truncated to 64 bits. Any count from 64 to 127 gives zero.
- R2: Opcode 0 in word mode uses a 6-bit count and puts the low 32 bits of the left-shifted source in bits 31:0. Bits 63:32 are zero. Any count of 32 or more makes bits 31:0 zero.
- R3: Opcode 1 (shift right) in word mode with the signedness flag low shifts bits 31:0 right logically, filling with zeros. Bits 63:32 are zero.
- R4: Opcode 1 in word mode with the signedness flag high shifts bits 31:0 right arithmetically. Every bit of 63:32 equals source bit 31.
- R5: Opcode 1 in doubleword mode with the signedness flag low is a logical right shift of all 64 bits by the 7-bit count. Any count of 64 or more gives zero.
- R6: Opcode 1 in doubleword mode with the signedness flag high is an arithmetic right shift by the 7-bit count. Any count of 64 or more gives 64 copies of source bit 63.
- R7: Opcode 2 in doubleword mode first sign-extends bits 31:0 of the source to 64 bits. It then shifts the extended value left by the 7-bit count and truncates the result to 64 bits.
- R8: Opcode 2 in word mode gives the same result as opcode 0 in word mode.
- R9: `ok` is 1 when the opcode is 0, 1 or 2. It is 0 when the opcode is 3, 4, 5, 6 or 7.
- R10: While `ok` is 0, `result` is all zeros.
- R11: `ctx_out` equals `ctx_in` and `muxid_out` equals `muxid_in` in the same cycle, whatever the opcode.
- R12: Bits of the count operand above the count field have no effect on `result`. In doubleword mode those are bits 63:7; in word mode they are bits 63:6. The signedness flag has no effect on `result` for opcodes 0 and 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_a | input | 64 | Source operand |
| shamt_b | input | 64 | Operand whose low bits give the shift count |
| opcode | input | 3 | Operation select: 0 left, 1 right, 2 sign-extend word then left |
| mode32 | input | 1 | High selects word mode |
| signed_op | input | 1 | High selects an arithmetic right shift |
| ctx_in | input | 16 | Operation record tag |
| muxid_in | input | 2 | Mux id tag |
| result | output | 64 | Shift result |
| ok | output | 1 | High when the opcode is supported |
| ctx_out | output | 16 | Operation record tag, passed through |
| muxid_out | output | 2 | Mux id tag, passed through |

## Verification
The embedded checks are combinational. They assume every input holds a known value and stays steady while the outputs settle. An undefined opcode or flag would make the decoded class, and therefore the check on `ok`, meaningless.

The bench respects this. It changes all inputs together, just after a rising clock edge, and compares outputs only at the following falling edge, once the logic has settled. Every operand is fully driven, including the count bits above the count field. Those bits are randomised on purpose, to exercise R12.

// File: rtl/shx_pkg.sv
package shx_pkg;

    localparam logic [2:0] OPC_SLL  = 3'd0;
    localparam logic [2:0] OPC_SR   = 3'd1;
    localparam logic [2:0] OPC_EXSL = 3'd2;

    typedef enum logic [1:0] {
        K_NONE  = 2'd0,
        K_LEFT  = 2'd1,
        K_RIGHT = 2'd2,
        K_EXTL  = 2'd3
    } shx_kind_e;

endpackage

// File: rtl/shx_decode.sv
module shx_decode
    import shx_pkg::*;
(
    input  logic [2:0] opcode,
    output shx_kind_e  kind,
    output logic       valid
);

    always_comb begin
        unique case (opcode)
            OPC_SLL:  kind = K_LEFT;
            OPC_SR:   kind = K_RIGHT;
            OPC_EXSL: kind = K_EXTL;
            default:  kind = K_NONE;
        endcase
    end

    always_comb begin
        unique case (kind)
            K_LEFT, K_RIGHT, K_EXTL: valid = 1'b1;
            default:                 valid = 1'b0;
        endcase
    end

endmodule

// File: rtl/shx_left.sv
module shx_left #(
    parameter int DATA_W = 64,
    parameter int AMT_W  = 7
) (
    input  logic [DATA_W-1:0] a,
    input  logic [AMT_W-1:0]  amt,
    input  logic              m32,
    input  logic              sext,
    output logic [DATA_W-1:0] res
);

    localparam int HALF_W = DATA_W / 2;

    logic [DATA_W-1:0] src;
    logic [DATA_W-1:0] wide;

    always_comb begin
        if (sext && !m32) begin
            src = {{HALF_W{a[HALF_W-1]}}, a[HALF_W-1:0]};
        end else begin
            src = a;
        end
        wide = src << amt;
        if (m32) begin
            res = {{HALF_W{1'b0}}, wide[HALF_W-1:0]};
        end else begin
            res = wide;
        end
    end

endmodule

// File: rtl/shx_right.sv
module shx_right #(
    parameter int DATA_W = 64,
    parameter int AMT_W  = 7
) (
    input  logic [DATA_W-1:0] a,
    input  logic [AMT_W-1:0]  amt,
    input  logic              m32,
    input  logic              sgn,
    output logic [DATA_W-1:0] res
);

    localparam int HALF_W = DATA_W / 2;

    logic signed [DATA_W-1:0] full_s;
    logic signed [HALF_W-1:0] lo_s;
    logic [HALF_W-1:0]        lo;
    logic [HALF_W-1:0]        hi;

    assign full_s = a;
    assign lo_s   = a[HALF_W-1:0];

    always_comb begin
        lo  = '0;
        hi  = '0;
        res = '0;
        if (m32) begin
            if (sgn) begin
                lo = lo_s >>> amt;
                hi = {HALF_W{a[HALF_W-1]}};
            end else begin
                lo = a[HALF_W-1:0] >> amt;
            end
            res = {hi, lo};
        end else if (sgn) begin
            res = full_s >>> amt;
        end else begin
            res = a >> amt;
        end
    end

endmodule

// File: rtl/shx_stage.sv
module shx_stage
    import shx_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int CTX_W  = 16,
    parameter int MUX_W  = 2
) (
    input  logic [DATA_W-1:0] src_a,
    input  logic [DATA_W-1:0] shamt_b,
    input  logic [2:0]        opcode,
    input  logic              mode32,
    input  logic              signed_op,
    input  logic [CTX_W-1:0]  ctx_in,
    input  logic [MUX_W-1:0]  muxid_in,
    output logic [DATA_W-1:0] result,
    output logic              ok,
    output logic [CTX_W-1:0]  ctx_out,
    output logic [MUX_W-1:0]  muxid_out
);

    localparam int HALF_W = DATA_W / 2;
    localparam int AMT_W  = $clog2(DATA_W) + 1;

    shx_kind_e         kind;
    logic              dec_ok;
    logic [AMT_W-1:0]  amt;
    logic [DATA_W-1:0] left_res;
    logic [DATA_W-1:0] right_res;

    shx_decode u_dec (
        .opcode (opcode),
        .kind   (kind),
        .valid  (dec_ok)
    );

    always_comb begin
        if (mode32) begin
            amt = {1'b0, shamt_b[AMT_W-2:0]};
        end else begin
            amt = shamt_b[AMT_W-1:0];
        end
    end

    shx_left #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_left (
        .a    (src_a),
        .amt  (amt),
        .m32  (mode32),
        .sext (kind == K_EXTL),
        .res  (left_res)
    );

    shx_right #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_right (
        .a    (src_a),
        .amt  (amt),
        .m32  (mode32),
        .sgn  (signed_op),
        .res  (right_res)
    );

    always_comb begin
        unique case (kind)
            K_LEFT, K_EXTL: result = left_res;
            K_RIGHT:        result = right_res;
            default:        result = '0;
        endcase
        ok = dec_ok;
    end

    assign ctx_out   = ctx_in;
    assign muxid_out = muxid_in;

    // Checks on the settled outputs, relating them to the input ports.
    always_comb begin
        p_ok_decode_r9: assert (ok == (opcode <= 3'd2))
            else $error("ok does not match opcode");
        p_idle_zero_r10: assert (ok || (result == '0))
            else $error("result nonzero while ok low");
        p_ctx_pass_r11: assert ((ctx_out == ctx_in) && (muxid_out == muxid_in))
            else $error("context tag altered");
        p_word_left_hi_r2: assert (!(mode32 && (opcode == 3'd0 || opcode == 3'd2))
                                   || (result[DATA_W-1:HALF_W] == '0))
            else $error("word left shift upper half not zero");
        p_word_sr_hi_r3: assert (!(mode32 && opcode == 3'd1 && !signed_op)
                                 || (result[DATA_W-1:HALF_W] == '0))
            else $error("word logical right upper half not zero");
        p_word_sra_hi_r4: assert (!(mode32 && opcode == 3'd1 && signed_op)
                                  || (result[DATA_W-1:HALF_W] == {HALF_W{src_a[HALF_W-1]}}))
            else $error("word arithmetic right upper half not sign");
        p_big_left_r1: assert (!(!mode32 && (opcode == 3'd0 || opcode == 3'd2)
                                 && shamt_b[AMT_W-1]) || (result == '0))
            else $error("left shift by 64 or more not zero");
        p_big_sra_r6: assert (!(!mode32 && opcode == 3'd1 && signed_op && shamt_b[AMT_W-1])
                              || (result == {DATA_W{src_a[DATA_W-1]}}))
            else $error("arithmetic right by 64 or more not sign fill");
    end

endmodule

// File: tb/sim_shx_stage.sv
module sim_shx_stage;

    logic        clk = 1'b0;
    logic [63:0] src_a = '0;
    logic [63:0] shamt_b = '0;
    logic [2:0]  opcode = 3'd7;
    logic        mode32 = 1'b0;
    logic        signed_op = 1'b0;
    logic [15:0] ctx_in = '0;
    logic [1:0]  muxid_in = '0;
    logic [63:0] result;
    logic        ok;
    logic [15:0] ctx_out;
    logic [1:0]  muxid_out;

    int unsigned total = 0;
    int unsigned bad = 0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    shx_stage u0 (
        .src_a     (src_a),
        .shamt_b   (shamt_b),
        .opcode    (opcode),
        .mode32    (mode32),
        .signed_op (signed_op),
        .ctx_in    (ctx_in),
        .muxid_in  (muxid_in),
        .result    (result),
        .ok        (ok),
        .ctx_out   (ctx_out),
        .muxid_out (muxid_out)
    );

    function automatic logic [63:0] ref_model(input logic [2:0] op, input logic m32,
                                              input logic sg, input logic [63:0] a,
                                              input logic [63:0] b);
        int n;
        logic [63:0] v;
        logic [31:0] w;
        logic fill;
        n = m32 ? int'(b[5:0]) : int'(b[6:0]);
        v = '0;
        case (op)
            3'd0, 3'd2: begin
                v = a;
                if (op == 3'd2 && !m32) begin
                    for (int i = 32; i < 64; i++) v[i] = a[31];
                end
                repeat (n) v = {v[62:0], 1'b0};
                if (m32) v[63:32] = '0;
            end
            3'd1: begin
                if (m32) begin
                    w = a[31:0];
                    fill = sg & a[31];
                    repeat (n) w = {fill, w[31:1]};
                    v = {(sg ? {32{a[31]}} : 32'h0), w};
                end else begin
                    v = a;
                    fill = sg & a[63];
                    repeat (n) v = {fill, v[63:1]};
                end
            end
            default: v = '0;
        endcase
        return v;
    endfunction

    function automatic string tag_of(input logic [2:0] op, input logic m32, input logic sg);
        case (op)
            3'd0: return m32 ? "R2" : "R1";
            3'd1: return m32 ? (sg ? "R4" : "R3") : (sg ? "R6" : "R5");
            3'd2: return m32 ? "R8" : "R7";
            default: return "R10";
        endcase
    endfunction

    task automatic note(input bit pass, input string req, input logic [63:0] act,
                        input logic [63:0] exp);
        total++;
        if (!pass) begin
            bad++;
            $display("FAIL %s op=%0d m32=%0b sgn=%0b a=%h b=%h actual=%h expected=%h",
                     req, opcode, mode32, signed_op, src_a, shamt_b, act, exp);
        end
    endtask

    task automatic run(input logic [2:0] op, input logic m32, input logic sg,
                       input logic [63:0] a, input logic [63:0] b, input string extra);
        logic [63:0] exp;
        logic [15:0] cx;
        logic [1:0]  mx;
        @(posedge clk);
        #1;
        cx = 16'($urandom);
        mx = 2'($urandom);
        opcode = op; mode32 = m32; signed_op = sg;
        src_a = a; shamt_b = b; ctx_in = cx; muxid_in = mx;
        @(negedge clk);
        exp = ref_model(op, m32, sg, a, b);
        note(result == exp, (extra != "") ? extra : tag_of(op, m32, sg), result, exp);
        note(ok == (op <= 3'd2), "R9", {63'h0, ok}, {63'h0, op <= 3'd2});
        note(ctx_out == cx && muxid_out == mx, "R11", {46'h0, ctx_out, muxid_out},
             {46'h0, cx, mx});
    endtask

    function automatic logic [63:0] rnd64();
        return {$urandom, $urandom};
    endfunction

    initial begin
        int amts[7] = '{0, 31, 32, 63, 64, 127, 1};
        logic [63:0] pats[4] = '{64'h8000_0000_8000_0001, 64'hFFFF_FFFF_FFFF_FFFF,
                                 64'h0123_4567_89AB_CDEF, 64'h7FFF_FFFF_7FFF_FFFE};
        logic [63:0] a, b, r1, r2;

        // Reset state: unsupported opcode idles the outputs (R9, R10)
        @(negedge clk);
        note(ok == 1'b0, "R9", {63'h0, ok}, 64'h0);
        note(result == '0, "R10", result, 64'h0);

        // Corner counts across every opcode, mode and signedness
        for (int op = 0; op < 8; op++)
            for (int m = 0; m < 2; m++)
                for (int s = 0; s < 2; s++)
                    for (int k = 0; k < 7; k++)
                        for (int p = 0; p < 4; p++) begin
                            b = rnd64();
                            b[6:0] = 7'(amts[k]);
                            run(3'(op), 1'(m), 1'(s), pats[p], b, "");
                        end

        // R12: upper count bits and, for left ops, the sign flag do not matter
        for (int t = 0; t < 200; t++) begin
            a = rnd64();
            b = rnd64();
            for (int op = 0; op < 3; op++) begin
                for (int m = 0; m < 2; m++) begin
                    run(3'(op), 1'(m), 1'b0, a, b, "");
                    r1 = result;
                    run(3'(op), 1'(m), (op != 1) ? 1'b1 : 1'b0, a,
                        {~b[63:7], b[6:0]} ^ (m ? 64'h40 : 64'h0), "");
                    r2 = result;
                    note(r1 == r2, "R12", r2, r1);
                end
            end
        end

        // Random sweep
        for (int t = 0; t < 3000; t++)
            run(3'($urandom), 1'($urandom), 1'($urandom), rnd64(), rnd64(), "");

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule